// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block watches for runaway software. A down-counter of `CNT_W` bits (15 by default) steps once per tick of a prescaler that divides the core clock. Two inputs set the divide ratio together: a clock-source select and a ratio-select bit. When the counter steps past zero it raises a one-cycle interrupt request. It then reloads to full scale and keeps counting, so the request repeats once every period until software services the block.

After reset the block does nothing until software makes its first service write. That write arms the block for good (only reset disarms it) and loads the counter to all ones. Each later service write reloads the counter but leaves the prescaler running. A freeze input, asserted during stop, wait or bus-hold states, stops both the prescaler and the counter at their current values. Counting resumes from those values when freeze falls. Bus decode and interrupt arbitration sit outside the block.

Top module: `wdog_top`

## Requirements
- R1: After reset `irq` stays 0 for as long as no service write occurs, whatever the select and freeze inputs do.
- R2: With `clk_src_sub` = 1 the prescaler divides by `DIV_SUB` (2) for either value of `pre_sel`.
- R3: With `clk_src_sub` = 0 and `pre_sel` = 0 the prescaler divides by `DIV_LO` (16).
- R4: With `clk_src_sub` = 0 and `pre_sel` = 1 the prescaler divides by `DIV_HI` (128).
- R5: Reset clears the prescaler. If the arming write is sampled at edge 0, `irq` is first high in the cycle after edge 2^CNT_W × D, where D is the divide ratio.
- R6: `irq` is high for exactly one cycle. The counter wraps to all ones, so without service the next pulse follows 2^CNT_W × D cycles later.
- R7: A service write sampled at edge t reloads the counter and does not clear the prescaler. The next `irq` follows edge (floor(t/D) + 2^CNT_W) × D.
- R8: When a service write and a prescaler tick fall on the same edge, the reload wins. This holds even on the edge that would underflow, and no `irq` is raised there.
- R9: While `freeze` = 1 the prescaler and the counter hold their values. Each frozen edge delays the next `irq` by one cycle.
- R10: A change of `pre_sel` or `clk_src_sub` takes effect only when the prescaler next wraps. The period in progress finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_src_sub | input | 1 | 1 = core runs from the slow sub-clock |
| pre_sel | input | 1 | Ratio select when on the main clock (0 = low, 1 = high) |
| svc_wr | input | 1 | Service-write strobe, one cycle per write |
| freeze | input | 1 | Holds prescaler and counter (stop, wait, hold) |
| irq | output | 1 | Watchdog interrupt request, one-cycle pulse |

## Verification
Two things can land on the same edge: a service-write reload and a prescaler tick, including the tick that would underflow. The bench places service writes on edges that are exact multiples of the divide ratio. One such edge is the underflow edge itself, and the bench also uses edges between ticks. For each case it computes the next interrupt edge arithmetically from floor(t/D). It judges priority by checking that no pulse appears at the underflow edge and that the next pulse arrives one full period later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Divide ratio chosen by the clock-source and ratio-select inputs.
  function automatic int unsigned wd_ratio(input logic sub, input logic sel,
                                           input int unsigned lo,
                                           input int unsigned hi,
                                           input int unsigned sb);
    if (sub)
      return sb;
    else if (sel)
      return hi;
    else
      return lo;
  endfunction

  function automatic int unsigned wd_max3(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Cycles from the arming write to the first request, with a fresh prescaler.
  function automatic int unsigned wd_period(input int unsigned cnt_w,
                                            input int unsigned div);
    return (32'd1 << cnt_w) * div;
  endfunction

endpackage

// File: rtl/wdog_arm.sv
module wdog_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_wr,
  output logic armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (svc_wr)
      armed <= 1'b1;
  end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_LO  = 16,
  parameter int unsigned DIV_HI  = 128,
  parameter int unsigned DIV_SUB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic freeze,
  input  logic clk_src_sub,
  input  logic pre_sel,
  output logic tick
);

  localparam int unsigned MAXD = wd_max3(DIV_LO, DIV_HI, DIV_SUB);
  localparam int unsigned PW   = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] term_q;
  logic [PW-1:0] term_req;
  logic          active;
  logic          wrap;

  assign term_req = PW'(wd_ratio(clk_src_sub, pre_sel, DIV_LO, DIV_HI, DIV_SUB) - 1);
  assign active   = armed & ~freeze;
  assign wrap     = active && (pre_q == term_q);
  assign tick     = wrap;

  // The terminal count follows the inputs while idle and is re-latched only on a wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      term_q <= PW'(DIV_LO - 1);
    end else if (!armed) begin
      pre_q  <= '0;
      term_q <= term_req;
    end else if (wrap) begin
      pre_q  <= '0;
      term_q <= term_req;
    end else if (active) begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  a_r9_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && freeze) |=> ($stable(pre_q) && $stable(term_q)));

  a_r10_ratio_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wrap) |=> $stable(term_q));

  a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= term_q);

endmodule

// File: rtl/wdog_down.sv
module wdog_down #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             svc_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic underflow;

  // A reload on the same edge cancels the underflow.
  assign underflow = tick && (cnt == '0) && !svc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= FULL;
      irq <= 1'b0;
    end else begin
      irq <= underflow;
      if (svc_wr)
        cnt <= FULL;
      else if (tick)
        cnt <= (cnt == '0) ? FULL : cnt - 1'b1;
    end
  end

  a_r8_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    svc_wr |=> (cnt == FULL && !irq));

  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !svc_wr) |=> $stable(cnt));

  a_r6_wrap_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == FULL));

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned DIV_LO  = 16,
  parameter int unsigned DIV_HI  = 128,
  parameter int unsigned DIV_SUB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_src_sub,
  input  logic pre_sel,
  input  logic svc_wr,
  input  logic freeze,
  output logic irq
);

  logic             armed;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  wdog_arm i_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .svc_wr (svc_wr),
    .armed  (armed)
  );

  wdog_prescaler #(
    .DIV_LO  (DIV_LO),
    .DIV_HI  (DIV_HI),
    .DIV_SUB (DIV_SUB)
  ) i_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed       (armed),
    .freeze      (freeze),
    .clk_src_sub (clk_src_sub),
    .pre_sel     (pre_sel),
    .tick        (tick)
  );

  wdog_down #(
    .CNT_W (CNT_W)
  ) i_down (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .svc_wr (svc_wr),
    .cnt    (cnt),
    .irq    (irq)
  );

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!irq && !tick));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r9_no_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !tick);

endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;

  localparam int W = 5;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_src_sub = 1'b0;
  logic pre_sel = 1'b0;
  logic svc_wr = 1'b0;
  logic freeze = 1'b0;
  logic irq;

  int cyc = 0;
  int c0 = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top #(.CNT_W(W)) i_wdog_top (
    .clk(clk), .rst_n(rst_n), .clk_src_sub(clk_src_sub),
    .pre_sel(pre_sel), .svc_wr(svc_wr), .freeze(freeze), .irq(irq)
  );

  function automatic int bdiv(input bit sub, input bit sel);
    return sub ? 2 : (16 << (3 * sel));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit sub, input bit sel);
    @(negedge clk);
    rst_n = 1'b0; svc_wr = 1'b0; freeze = 1'b0;
    clk_src_sub = sub; pre_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic arm();
    svc_wr = 1'b1;
    c0 = cyc + 1;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic goto_edge(input int off);
    while (cyc < c0 + off - 1) @(negedge clk);
  endtask

  task automatic svc_at(input int off);
    goto_edge(off);
    svc_wr = 1'b1;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic wait_irq(input int limit, output int lat);
    lat = -1;
    while (cyc < c0 + limit) begin
      if (irq) begin
        lat = cyc - c0;
        return;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int lat;
    int pulses;
    int d;
    @(negedge clk);
    check(irq == 1'b0, "R1 reset", irq, 0);
    do_reset(1'b1, 1'b0);

    // R1: never armed, inputs wander
    pulses = 0;
    for (int k = 0; k < 6000; k++) begin
      clk_src_sub = k[9]; pre_sel = k[8]; freeze = k[5];
      @(negedge clk);
      if (irq) pulses++;
    end
    check(pulses == 0, "R1 idle", pulses, 0);

    // R2/R3/R4/R5/R6: sweep all select combinations
    for (int m = 0; m < 4; m++) begin
      do_reset(m[1], m[0]);
      d = bdiv(m[1], m[0]);
      arm();
      wait_irq(N * d + 50, lat);
      if (m[1]) check(lat == N * d, "R2 sub ratio", lat, N * d);
      else if (m[0]) check(lat == N * d, "R4 high ratio", lat, N * d);
      else check(lat == N * d, "R3 low ratio", lat, N * d);
      check(lat == N * d, "R5 first latency", lat, N * d);
      @(negedge clk);
      check(irq == 1'b0, "R6 pulse width", irq, 0);
      wait_irq(2 * N * d + 50, lat);
      check(lat == 2 * N * d, "R6 repeat", lat, 2 * N * d);
    end

    // R7: service between ticks keeps prescaler phase
    do_reset(1'b0, 1'b0);
    arm();
    svc_at(37);
    wait_irq(2000, lat);
    check(lat == (37 / 16 + N) * 16, "R7 service mid", lat, (37 / 16 + N) * 16);

    // R8: service on a tick edge
    do_reset(1'b0, 1'b0);
    arm();
    svc_at(48);
    wait_irq(2000, lat);
    check(lat == (3 + N) * 16, "R8 service on tick", lat, (3 + N) * 16);

    // R8: service on the underflow edge suppresses the pulse
    do_reset(1'b0, 1'b0);
    arm();
    svc_at(N * 16);
    wait_irq(4000, lat);
    check(lat == 2 * N * 16, "R8 service on underflow", lat, 2 * N * 16);

    // R9: freeze with the fast ratio
    do_reset(1'b1, 1'b0);
    arm();
    goto_edge(10);
    freeze = 1'b1;
    goto_edge(17);
    freeze = 1'b0;
    wait_irq(500, lat);
    check(lat == N * 2 + 7, "R9 freeze sub", lat, N * 2 + 7);

    // R9: freeze in mid prescaler with the slow ratio
    do_reset(1'b0, 1'b1);
    arm();
    goto_edge(50);
    freeze = 1'b1;
    goto_edge(150);
    freeze = 1'b0;
    wait_irq(8000, lat);
    check(lat == N * 128 + 100, "R9 freeze main", lat, N * 128 + 100);

    // R10: low to high ratio change waits for the wrap
    do_reset(1'b0, 1'b0);
    arm();
    goto_edge(5);
    pre_sel = 1'b1;
    wait_irq(8000, lat);
    check(lat == 16 + (N - 1) * 128, "R10 low to high", lat, 16 + (N - 1) * 128);

    // R10: main to sub-clock change waits for the wrap
    do_reset(1'b0, 1'b1);
    arm();
    goto_edge(5);
    clk_src_sub = 1'b1;
    wait_irq(8000, lat);
    check(lat == 128 + (N - 1) * 2, "R10 to sub", lat, 128 + (N - 1) * 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule